// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This controller services one cache read miss at a time by pulling a whole multi-word block from memory into a cache line. It can run in two modes. In critical-first mode it asks memory for the missed word before any other word. It hands that word to the processor in the cycle it arrives, and then fetches the rest of the block. In in-order mode it fetches the block from word 0 upward and releases the processor in the cycle the missed word comes back. In both modes the remaining words keep streaming into the line after the processor has been released.

A miss carries a block address, a word offset and a mode bit. The controller issues word reads on a request channel with a valid/ready handshake. Several reads may be outstanding, and responses come back in request order. Every returned word is written through a line write port that gives the word index and the data. When the last word has been written, a one-cycle tag write marks the line valid under the block address. While a fill is running, the busy output stays high and new misses are refused.

Top module: `line_refill_ctrl`

## Requirements
- R1: When `busy` is low, a cycle with `miss_valid` high latches block, offset and mode. `busy` is high from the next cycle and stays high until the fill completes. After reset `busy`, `mem_req_valid`, `line_we`, `cpu_valid` and `tag_we` are all low.
- R2: With `miss_mode` = 0 (critical-first), the first memory request targets the missed word. The first response is written to that word index and forwarded to the processor in the same cycle.
- R3: In critical-first mode the remaining words are requested in ascending index order starting at 0, skipping the missed word.
- R4: With `miss_mode` = 1 (in-order), words are requested and written in order 0 to WORDS-1. `cpu_valid` rises in the cycle the response for the missed word arrives.
- R5: Each response accepted during a fill drives `line_we` high in the same cycle, with `line_data` equal to the response data and `line_idx` following the request order. Over one fill, every index is written exactly once.
- R6: `cpu_valid` is a one-cycle pulse, asserted exactly once per fill. `cpu_data` carries the missed word.
- R7: `tag_we` pulses for exactly one cycle, in the cycle after the last word's write, with `tag_blk` equal to the latched block address. `busy` is low from the following cycle.
- R8: `miss_valid` raised while `busy` is high has no effect: requests, writes and the tag keep using the original miss.
- R9: `mem_req_addr` is the block address in the upper bits and the word index in the low log2(WORDS) bits. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady. `mem_req_valid` is high exactly while requests of the current fill remain unissued.
- R10: A response arriving when no fill is running causes no line write and no processor forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_blk | input | BLK_W | Block address of the miss |
| miss_off | input | log2(WORDS) | Word offset of the missed word |
| miss_mode | input | 1 | 0 critical-first, 1 in-order |
| busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | BLK_W+log2(WORDS) | Word address {block, index} |
| mem_rsp_valid | input | 1 | Memory response strobe (in request order) |
| mem_rsp_data | input | DATA_W | Memory response data |
| line_we | output | 1 | Cache line word write enable |
| line_idx | output | log2(WORDS) | Word index within the line |
| line_data | output | DATA_W | Word written to the line |
| tag_we | output | 1 | Tag/valid write at fill completion |
| tag_blk | output | BLK_W | Block address written to the tag |
| cpu_valid | output | 1 | Processor restart pulse |
| cpu_data | output | DATA_W | Missed word to the processor |

## Verification
The bench aims at offsets at both ends of the line in both modes. There the skip-the-critical-word order is most likely to break: a design that got it wrong would fetch the missed word twice or leave one index unwritten. It varies memory backpressure and response gaps. A controller that let the address slip under a stalled handshake, or that miscounted outstanding words, would write data to the wrong index. It raises a second miss during a fill, which would corrupt the request addresses if it were accepted. It also checks that the tag pulse and the release of `busy` come only after the final word, and that the processor receives exactly one pulse, carrying the missed word.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic {
    FILL_CRIT_FIRST = 1'b0,
    FILL_IN_ORDER   = 1'b1
  } fill_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_TAG  = 2'd2
  } fill_state_e;

endpackage

// File: rtl/refill_counter.sv
module refill_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/refill_order.sv
module refill_order
  import refill_pkg::*;
#(
  parameter  int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = OFF_W + 1
) (
  input  fill_mode_e       mode,
  input  logic [OFF_W-1:0] crit,
  input  logic [CNT_W-1:0] step,
  output logic [OFF_W-1:0] word
);

  // Step k of a fill maps to a word index. In-order mode: k itself.
  // Critical-first: step 0 is the critical word, later steps walk upward
  // from 0 and jump over the critical index.
  function automatic logic [OFF_W-1:0] slot_for_step(
    input fill_mode_e       m,
    input logic [OFF_W-1:0] c,
    input logic [CNT_W-1:0] k
  );
    logic [CNT_W-1:0] rest;
    if (m == FILL_IN_ORDER) return k[OFF_W-1:0];
    if (k == '0) return c;
    rest = k - CNT_W'(1);
    if (rest >= {1'b0, c}) return OFF_W'(rest + CNT_W'(1));
    return rest[OFF_W-1:0];
  endfunction

  assign word = slot_for_step(mode, crit, step);

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import refill_pkg::*;
#(
  parameter  int WORDS  = 8,
  parameter  int BLK_W  = 24,
  parameter  int DATA_W = 32,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [BLK_W-1:0]  miss_blk,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic              miss_mode,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              line_we,
  output logic [OFF_W-1:0]  line_idx,
  output logic [DATA_W-1:0] line_data,
  output logic              tag_we,
  output logic [BLK_W-1:0]  tag_blk,
  output logic              cpu_valid,
  output logic [DATA_W-1:0] cpu_data
);

  localparam int CNT_W = OFF_W + 1;

  fill_state_e       state_q, state_d;
  logic [BLK_W-1:0]  blk_q;
  logic [OFF_W-1:0]  off_q;
  fill_mode_e        mode_q;

  // named internal events
  logic              accept;
  logic              req_fire;
  logic              req_done;
  logic              rsp_take;
  logic              rsp_last;
  logic              crit_hit;
  logic [CNT_W-1:0]  req_cnt;
  logic [CNT_W-1:0]  rsp_cnt;
  logic [OFF_W-1:0]  req_word;
  logic [OFF_W-1:0]  rsp_word;

  assign accept   = miss_valid && (state_q == ST_IDLE);
  assign req_done = (req_cnt == CNT_W'(WORDS));
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_take = mem_rsp_valid && (state_q == ST_FILL);
  assign rsp_last = rsp_take && (rsp_cnt == CNT_W'(WORDS - 1));
  assign crit_hit = rsp_take && (rsp_word == off_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      off_q  <= '0;
      mode_q <= FILL_CRIT_FIRST;
    end else if (accept) begin
      blk_q  <= miss_blk;
      off_q  <= miss_off;
      mode_q <= fill_mode_e'(miss_mode);
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)   state_d = ST_FILL;
      ST_FILL: if (rsp_last) state_d = ST_TAG;
      ST_TAG:                state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  refill_counter #(.CNT_W(CNT_W)) u_req_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (req_fire),
    .cnt   (req_cnt)
  );

  refill_counter #(.CNT_W(CNT_W)) u_rsp_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (rsp_take),
    .cnt   (rsp_cnt)
  );

  refill_order #(.WORDS(WORDS)) u_req_order (
    .mode (mode_q),
    .crit (off_q),
    .step (req_cnt),
    .word (req_word)
  );

  refill_order #(.WORDS(WORDS)) u_rsp_order (
    .mode (mode_q),
    .crit (off_q),
    .step (rsp_cnt),
    .word (rsp_word)
  );

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_FILL) && !req_done;
  assign mem_req_addr  = {blk_q, req_word};

  assign line_we   = rsp_take;
  assign line_idx  = rsp_word;
  assign line_data = mem_rsp_data;

  assign cpu_valid = crit_hit;
  assign cpu_data  = mem_rsp_data;

  assign tag_we  = (state_q == ST_TAG);
  assign tag_blk = blk_q;

endmodule

// File: rtl/line_refill_checker.sv
module line_refill_checker #(
  parameter  int WORDS = 8,
  parameter  int BLK_W = 24,
  localparam int OFF_W = $clog2(WORDS),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              line_we,
  input logic [OFF_W-1:0]  line_idx,
  input logic              tag_we,
  input logic              cpu_valid,
  input logic [BLK_W-1:0]  blk_q,
  input logic [OFF_W-1:0]  off_q,
  input logic              mode_bit
);

  logic [WORDS-1:0] wmask;
  logic             fwd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      wmask    <= '0;
      fwd_seen <= 1'b0;
    end else begin
      if (line_we)   wmask[line_idx] <= 1'b1;
      if (cpu_valid) fwd_seen        <= 1'b1;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_no_rewrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |-> (busy && !wmask[line_idx]));

  assert_crit_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && (wmask == '0) && !mode_bit) |-> cpu_valid);

  assert_in_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && mode_bit) |-> (line_idx == OFF_W'($countones(wmask))));

  assert_single_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> (line_we && (line_idx == off_q) && !fwd_seen));

  assert_pulse_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> !cpu_valid);

  assert_full_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> ((&wmask) && fwd_seen && !line_we));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> !busy);

  assert_blk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(blk_q)));

endmodule

bind line_refill_ctrl line_refill_checker #(.WORDS(WORDS), .BLK_W(BLK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .line_we       (line_we),
  .line_idx      (line_idx),
  .tag_we        (tag_we),
  .cpu_valid     (cpu_valid),
  .blk_q         (blk_q),
  .off_q         (off_q),
  .mode_bit      (mode_q)
);

// File: tb/line_refill_ctrl_tb.sv
module line_refill_ctrl_tb;

  localparam int WORDS  = 8;
  localparam int BLK_W  = 24;
  localparam int DATA_W = 32;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int ADDR_W = BLK_W + OFF_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              miss_valid;
  logic [BLK_W-1:0]  miss_blk;
  logic [OFF_W-1:0]  miss_off;
  logic              miss_mode;
  logic              busy;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;
  logic              line_we;
  logic [OFF_W-1:0]  line_idx;
  logic [DATA_W-1:0] line_data;
  logic              tag_we;
  logic [BLK_W-1:0]  tag_blk;
  logic              cpu_valid;
  logic [DATA_W-1:0] cpu_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  line_refill_ctrl #(.WORDS(WORDS), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_dut (
    .clk, .rst_n, .miss_valid, .miss_blk, .miss_off, .miss_mode, .busy,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .line_we, .line_idx, .line_data, .tag_we, .tag_blk, .cpu_valid, .cpu_data
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [31:0] x;
    x = 32'(a);
    return (x * 32'h0001_0003) ^ 32'hA5C3_0F0F;
  endfunction

  // Expected index for fill position p, built as a list: critical word,
  // then all others from 0 upward (critical-first), or plain 0..WORDS-1.
  function automatic logic [OFF_W-1:0] exp_index(input bit mode, input logic [OFF_W-1:0] off, input int p);
    logic [OFF_W-1:0] lst [WORDS];
    int n = 0;
    if (mode) begin
      for (int i = 0; i < WORDS; i++) lst[i] = OFF_W'(i);
    end else begin
      lst[0] = off;
      n = 1;
      for (int i = 0; i < WORDS; i++)
        if (OFF_W'(i) != off) begin lst[n] = OFF_W'(i); n++; end
    end
    return lst[p];
  endfunction

  task automatic do_fill(input logic [BLK_W-1:0] blk, input logic [OFF_W-1:0] off,
                         input bit mode, input int rdy_pct, input int rsp_pct, input bit inject);
    logic [ADDR_W-1:0] pend [64];
    int ph = 0, pt = 0, reqk = 0, rspk = 0, fwd = 0, cyc = 0;
    logic [ADDR_W-1:0] exp_addr;
    logic [DATA_W-1:0] dat;
    @(negedge clk);
    miss_valid = 1'b1; miss_blk = blk; miss_off = off; miss_mode = mode;
    mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    check(busy === 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
    while (rspk < WORDS && cyc < 2000) begin
      mem_req_ready = (($urandom % 100) < 32'(rdy_pct));
      if (ph < pt && (($urandom % 100) < 32'(rsp_pct))) begin
        mem_rsp_valid = 1'b1;
        dat = mem_word(pend[ph]);
        mem_rsp_data = dat;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = $urandom;
      end
      miss_valid = inject && (cyc == 3);
      miss_blk   = ~blk;
      miss_off   = off + 1'b1;
      #1;
      check(mem_req_valid === (reqk < WORDS), "R9 request valid window", 64'(mem_req_valid), 64'(reqk < WORDS));
      if (mem_req_valid && reqk < WORDS) begin
        exp_addr = {blk, exp_index(mode, off, reqk)};
        check(mem_req_addr === exp_addr, mode ? "R4 request order" : "R3 request order (R2 first)",
              64'(mem_req_addr), 64'(exp_addr));
        if (mem_req_ready) begin pend[pt] = mem_req_addr; pt++; reqk++; end
      end
      if (mem_rsp_valid) begin
        check(line_we === 1'b1 && line_idx === exp_index(mode, off, rspk) && line_data === dat,
              "R5 line write", {31'd0, line_we, 32'(line_idx)}, {31'd0, 1'b1, 32'(exp_index(mode, off, rspk))});
        check(cpu_valid === (exp_index(mode, off, rspk) == off), mode ? "R4 forward timing" : "R2 forward timing",
              64'(cpu_valid), 64'(exp_index(mode, off, rspk) == off));
        if (cpu_valid) begin
          fwd++;
          check(cpu_data === dat, "R6 forwarded data", 64'(cpu_data), 64'(dat));
        end
        ph++; rspk++;
      end else begin
        check(line_we === 1'b0 && cpu_valid === 1'b0, "R5 no write without response",
              {62'd0, line_we, cpu_valid}, 64'd0);
      end
      check(tag_we === 1'b0, "R7 no early tag", 64'(tag_we), 64'd0);
      @(negedge clk);
      cyc++;
    end
    mem_rsp_valid = 1'b0; mem_req_ready = 1'b0; miss_valid = 1'b0;
    if (cyc >= 2000) check(1'b0, "R1 fill watchdog", 64'(rspk), 64'(WORDS));
    #1;
    check(tag_we === 1'b1 && tag_blk === blk && busy === 1'b1, "R7 tag pulse",
          {38'd0, tag_we, 1'b0, tag_blk}, {38'd0, 1'b1, 1'b0, blk});
    check(fwd == 1, "R6 one forward per fill", 64'(fwd), 64'd1);
    @(negedge clk);
    #1;
    check(busy === 1'b0 && tag_we === 1'b0, inject ? "R8 second miss ignored" : "R7 busy release",
          {62'd0, busy, tag_we}, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "R1 global watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; miss_valid = 1'b0; miss_blk = '0; miss_off = '0; miss_mode = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(busy === 1'b0 && mem_req_valid === 1'b0 && line_we === 1'b0 && cpu_valid === 1'b0 && tag_we === 1'b0,
          "R1 reset state", {59'd0, busy, mem_req_valid, line_we, cpu_valid, tag_we}, 64'd0);

    // R10: stray response while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
    #1;
    check(line_we === 1'b0 && cpu_valid === 1'b0 && busy === 1'b0, "R10 idle response ignored",
          {61'd0, line_we, cpu_valid, busy}, 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b0;

    // directed corners
    do_fill(24'h00_1234, 3'd0, 1'b0, 100, 100, 1'b0);
    do_fill(24'h00_5678, 3'd7, 1'b0, 100, 100, 1'b0);
    do_fill(24'hAB_CDEF, 3'd7, 1'b1, 100, 100, 1'b0);
    do_fill(24'h12_0000, 3'd0, 1'b1, 40, 60, 1'b0);
    do_fill(24'h0F_0F0F, 3'd4, 1'b0, 30, 30, 1'b1);
    do_fill(24'h33_3333, 3'd2, 1'b1, 50, 50, 1'b1);

    // random fills
    for (int n = 0; n < 40; n++) begin
      do_fill(BLK_W'($urandom), OFF_W'($urandom), 1'($urandom), 20 + int'($urandom % 81),
              20 + int'($urandom % 81), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule